// File: doc/BRIEF.md
# Receive Cell Header Discard Filter

This block sits on a byte-wide receive cell stream in which every cell is 53 octets long and its first header octet carries a start flag. It evaluates the first four header octets of each cell against an 8-bit compare value and an 8-bit don't-care mask. Only two nibbles are programmable: the upper nibble of the first octet and the lower nibble of the fourth. Every other header bit has to be zero. A cell that matches is removed in full, so cells that carry no user data never reach the cell layer. Idle cells, unassigned cells and physical-layer cells are the usual targets.

Octets travel through a short delay line that advances only when an input octet is accepted. The keep-or-drop decision is therefore known when the fourth header octet arrives, and the first three octets are still inside the block at that point. Surviving cells leave with the same framing. For each removed cell the block raises a discard pulse and advances a saturating counter. A start flag that arrives early restarts the framing and raises a framing-error pulse.

Top module: `cell_hdr_filter`

## Requirements
- R1: After reset, `out_valid`, `out_soc`, `drop_pulse` and `frame_err` are 0 and `drop_count` is 0.
- R2: A cell that does not match leaves unchanged: 53 octets, with `out_soc` set on the first one only. Input octet n appears on the output in the cycle after input octet n+DEPTH is accepted. With DEPTH=4, the first output octet follows the fifth accepted input octet.
- R3: Compare bits 7:4 are checked against bits 7:4 of header octet 1, and compare bits 3:0 against bits 3:0 of header octet 4. A mask bit of 1 makes the matching compared bit a don't-care. A mask bit of 0 requires equality.
- R4: A cell matches only if bits 3:0 of octet 1, all bits of octets 2 and 3, and bits 7:4 of octet 4 are zero, whatever the mask is set to.
- R5: With compare 0x01 and mask 0x00, idle cells (header 00 00 00 01) are removed. A cell with header 00 00 00 09 is kept.
- R6: With compare 0x01 and mask 0xFE, every cell with header PPPP0000 00 00 0000PPP1 is removed. A cell whose octet-4 bit 0 is 0 is kept.
- R7: With compare 0x00 and mask 0x0E, cells with header 00 00 00 0000XXX0 are removed and idle cells are kept.
- R8: For a removed cell, none of its 53 octets appear on the output. This includes the three octets that arrived before the decision.
- R9: The compare value and the mask are sampled with the start octet. A change during a cell has no effect on that cell.
- R10: Each removed cell gives exactly one `drop_pulse` cycle and adds one to `drop_count`. The counter holds at 2^CNT_W-1 once it reaches that value.
- R11: A start flag that arrives before a cell's 53 octets are complete gives one `frame_err` pulse and starts a new cell. A partial cell cut short before its fourth octet is forwarded unfiltered.
- R12: Cycles with `in_valid` low change neither the framing nor the output order. The output advances only on accepted input octets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input octet strobe |
| in_soc | input | 1 | Input octet is first header octet |
| in_data | input | 8 | Input octet |
| cfg_pattern | input | 8 | Compare value: [7:4] octet 1 high, [3:0] octet 4 low |
| cfg_dontcare | input | 8 | Per-bit don't-care mask for cfg_pattern |
| out_valid | output | 1 | Output octet strobe |
| out_soc | output | 1 | Output octet is first header octet |
| out_data | output | 8 | Output octet |
| drop_pulse | output | 1 | One cycle per removed cell |
| frame_err | output | 1 | One cycle per early start flag |
| drop_count | output | CNT_W | Saturating count of removed cells |

## Verification
The bench builds the filter with DEPTH=4 and CNT_W=3. At that counter width, nine removed cells are enough to push `drop_count` past its 7 ceiling and confirm it holds there. The minimal delay depth also sets the tightest case for the decision: header octets 1 to 3 are one stage from the output when octet 4 arrives, and the first output octet must follow the fifth input octet exactly.

// File: rtl/cellf_pkg.sv
package cellf_pkg;
    localparam int HDR_LEN  = 4;
    localparam int CELL_LEN = 53;

    typedef struct packed {
        logic       full;
        logic       soc;
        logic       drop;
        logic [7:0] data;
    } cellf_slot_t;
endpackage

// File: rtl/cellf_hdr_cmp.sv
module cellf_hdr_cmp (
    input  logic [1:0] idx,
    input  logic [7:0] data,
    input  logic [7:0] pat,
    input  logic [7:0] msk,
    output logic       ok
);
    logic [3:0] hi_diff;
    logic [3:0] lo_diff;

    always_comb begin
        hi_diff = (data[7:4] ^ pat[7:4]) & ~msk[7:4];
        lo_diff = (data[3:0] ^ pat[3:0]) & ~msk[3:0];
        unique case (idx)
            2'd0:    ok = (hi_diff == 4'd0) && (data[3:0] == 4'd0);
            2'd3:    ok = (data[7:4] == 4'd0) && (lo_diff == 4'd0);
            default: ok = (data == 8'd0);
        endcase
    end
endmodule

// File: rtl/cellf_delay_line.sv
module cellf_delay_line
    import cellf_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int MARK_N = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] push_data,
    input  logic       push_soc,
    input  logic       push_drop,
    input  logic       mark,
    output logic       out_valid,
    output logic       out_soc,
    output logic [7:0] out_data
);
    typedef struct packed {
        cellf_slot_t [DEPTH-1:0] slot;
        cellf_slot_t             outp;
    } dl_state_t;

    dl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.outp = '0;
        if (push) begin
            st_d.outp.full = st_q.slot[DEPTH-1].full & ~st_q.slot[DEPTH-1].drop;
            st_d.outp.soc  = st_q.slot[DEPTH-1].soc & st_d.outp.full;
            st_d.outp.data = st_q.slot[DEPTH-1].data;
            st_d.slot[0]   = '{full: 1'b1, soc: push_soc, drop: push_drop, data: push_data};
            for (int k = 1; k < DEPTH; k++) begin
                st_d.slot[k] = st_q.slot[k-1];
                if (mark && (k - 1) < MARK_N)
                    st_d.slot[k].drop = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.outp.full;
    assign out_soc   = st_q.outp.soc;
    assign out_data  = st_q.outp.data;

    // R12
    out_follows_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(push));
endmodule

// File: rtl/cellf_sat_counter.sv
module cellf_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && cnt_q != {W{1'b1}})
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R10
    cnt_sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == {W{1'b1}}) |=> (cnt_q == {W{1'b1}}));

    // R10
    cnt_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt_q));
endmodule

// File: rtl/cell_hdr_filter.sv
module cell_hdr_filter
    import cellf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_soc,
    input  logic [7:0]       in_data,
    input  logic [7:0]       cfg_pattern,
    input  logic [7:0]       cfg_dontcare,
    output logic             out_valid,
    output logic             out_soc,
    output logic [7:0]       out_data,
    output logic             drop_pulse,
    output logic             frame_err,
    output logic [CNT_W-1:0] drop_count
);
    localparam int POS_W = $clog2(CELL_LEN);

    typedef struct packed {
        logic             in_cell;
        logic [POS_W-1:0] pos;
        logic             hdr_ok;
        logic             dropping;
        logic [7:0]       pat;
        logic [7:0]       msk;
        logic             drop_pulse;
        logic             frame_err;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic [1:0] cmp_idx;
    logic [7:0] cmp_pat, cmp_msk;
    logic       byte_ok;
    logic       in_body;
    logic       decide;
    logic       hit;
    logic       push_drop;

    assign cmp_idx = in_soc ? 2'd0 : st_q.pos[1:0];
    assign cmp_pat = in_soc ? cfg_pattern  : st_q.pat;
    assign cmp_msk = in_soc ? cfg_dontcare : st_q.msk;

    cellf_hdr_cmp u_cmp (
        .idx  (cmp_idx),
        .data (in_data),
        .pat  (cmp_pat),
        .msk  (cmp_msk),
        .ok   (byte_ok)
    );

    always_comb begin
        in_body   = in_valid && !in_soc && st_q.in_cell;
        decide    = in_body && (st_q.pos == POS_W'(HDR_LEN - 1));
        hit       = decide && st_q.hdr_ok && byte_ok;
        push_drop = hit || (in_body && st_q.dropping);

        st_d            = st_q;
        st_d.drop_pulse = 1'b0;
        st_d.frame_err  = 1'b0;
        if (in_valid && in_soc) begin
            st_d.frame_err = st_q.in_cell;
            st_d.in_cell   = 1'b1;
            st_d.pos       = POS_W'(1);
            st_d.hdr_ok    = byte_ok;
            st_d.dropping  = 1'b0;
            st_d.pat       = cfg_pattern;
            st_d.msk       = cfg_dontcare;
        end else if (in_body) begin
            if (st_q.pos < POS_W'(HDR_LEN - 1))
                st_d.hdr_ok = st_q.hdr_ok && byte_ok;
            if (decide) begin
                st_d.dropping   = hit;
                st_d.drop_pulse = hit;
            end
            if (st_q.pos == POS_W'(CELL_LEN - 1)) begin
                st_d.in_cell  = 1'b0;
                st_d.pos      = '0;
                st_d.dropping = 1'b0;
            end else begin
                st_d.pos = st_q.pos + POS_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cellf_delay_line #(
        .DEPTH  (DEPTH),
        .MARK_N (HDR_LEN - 1)
    ) u_dline (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (in_valid),
        .push_data (in_data),
        .push_soc  (in_soc),
        .push_drop (push_drop),
        .mark      (hit),
        .out_valid (out_valid),
        .out_soc   (out_soc),
        .out_data  (out_data)
    );

    cellf_sat_counter #(
        .W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (hit),
        .count (drop_count)
    );

    assign drop_pulse = st_q.drop_pulse;
    assign frame_err  = st_q.frame_err;

    // R11
    ferr_after_soc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> $past(in_valid && in_soc));

    // R8
    drop_after_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |-> $past(in_valid && !in_soc));

    // R10
    drop_ferr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drop_pulse && frame_err));

    // R2
    soc_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_soc |-> out_valid);
endmodule

// File: tb/test_cell_hdr_filter.sv
`timescale 1ns/1ps
module test_cell_hdr_filter;
    localparam int DEPTH = 4;
    localparam int CNT_W = 3;
    localparam int CLEN  = 53;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_soc = 1'b0;
    logic [7:0]       in_data = 8'd0;
    logic [7:0]       cfg_pattern = 8'd0;
    logic [7:0]       cfg_dontcare = 8'd0;
    logic             out_valid, out_soc, drop_pulse, frame_err;
    logic [7:0]       out_data;
    logic [CNT_W-1:0] drop_count;

    always #2.5 clk = ~clk;

    cell_hdr_filter #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_cell_hdr_filter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_soc(in_soc),
        .in_data(in_data), .cfg_pattern(cfg_pattern), .cfg_dontcare(cfg_dontcare),
        .out_valid(out_valid), .out_soc(out_soc), .out_data(out_data),
        .drop_pulse(drop_pulse), .frame_err(frame_err), .drop_count(drop_count)
    );

    int nchk = 0, nerr = 0;
    int cyc = 0;
    int sent = 0;
    int ncap = 0, npulse = 0, nferr = 0, first_out_sent = -1;
    logic [8:0] cap [1024];
    logic [8:0] expq [1024];
    int nexp = 0, exp_drops = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) sent <= 0;
        else if (in_valid) sent <= sent + 1;
        if (cyc > 150000) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            ncap = 0; npulse = 0; nferr = 0; first_out_sent = -1;
        end else begin
            if (out_valid) begin
                if (first_out_sent < 0) first_out_sent = sent;
                if (ncap < 1024) cap[ncap] = {out_soc, out_data};
                ncap++;
            end
            if (drop_pulse) npulse++;
            if (frame_err) nferr++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic bit model_drop(input logic [7:0] h1, h2, h3, h4, p, m);
        bit hi_ok = (((h1[7:4] ^ p[7:4]) & ~m[7:4]) == 4'd0);
        bit lo_ok = (((h4[3:0] ^ p[3:0]) & ~m[3:0]) == 4'd0);
        return hi_ok && lo_ok && h1[3:0] == 0 && h2 == 0 && h3 == 0 && h4[7:4] == 0;
    endfunction

    task automatic put(input logic [7:0] d, input logic s);
        in_valid = 1'b1; in_data = d; in_soc = s;
        @(negedge clk);
    endtask

    task automatic gap(input int n);
        in_valid = 1'b0; in_soc = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [7:0] p, input logic [7:0] m);
        in_valid = 1'b0; in_soc = 1'b0; rst_n = 1'b0;
        cfg_pattern = p; cfg_dontcare = m;
        nexp = 0; exp_drops = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_cell(input logic [7:0] h1, h2, h3, h4, input int seed,
                             input bit gaps, input bit chg,
                             input logic [7:0] np, input logic [7:0] nm);
        logic [7:0] b;
        bit drop = model_drop(h1, h2, h3, h4, cfg_pattern, cfg_dontcare);
        if (drop) exp_drops++;
        for (int i = 0; i < CLEN; i++) begin
            b = (i == 0) ? h1 : (i == 1) ? h2 : (i == 2) ? h3 : (i == 3) ? h4 : 8'(seed + i);
            put(b, i == 0);
            if (!drop) begin expq[nexp] = {(i == 0), b}; nexp++; end
            if (chg && i == 0) begin cfg_pattern = np; cfg_dontcare = nm; end
            if (gaps && (i % 7) == 3) gap(2);
        end
    endtask

    task automatic send_partial(input int n);
        for (int i = 0; i < n; i++) begin
            put(8'h00, i == 0);
            expq[nexp] = {(i == 0), 8'h00}; nexp++;
        end
    endtask

    task automatic flush_and_compare(input string req);
        int bad = -1;
        for (int i = 0; i < DEPTH; i++) put(8'hEE, 1'b0);
        gap(4);
        chk(ncap == nexp, {req, " octet count"}, ncap, nexp);
        for (int i = 0; i < nexp && i < ncap; i++)
            if (bad < 0 && cap[i] !== expq[i]) bad = i;
        if (bad >= 0) chk(1'b0, {req, " octet content"}, int'(cap[bad]), int'(expq[bad]));
        else          chk(1'b1, {req, " octet content"}, 0, 0);
        chk(npulse == exp_drops, {req, " drop pulses"}, npulse, exp_drops);
    endtask

    task automatic t_reset();
        do_reset(8'h01, 8'h00);
        // R1
        chk(out_valid === 1'b0 && out_soc === 1'b0, "R1 out idle", int'(out_valid), 0);
        chk(drop_pulse === 1'b0 && frame_err === 1'b0, "R1 pulses idle", int'(drop_pulse), 0);
        chk(drop_count === '0, "R1 counter", int'(drop_count), 0);
    endtask

    task automatic t_pass();
        do_reset(8'h01, 8'h00);
        send_cell(8'h12, 8'h34, 8'h56, 8'h78, 5, 1'b0, 1'b0, 0, 0);
        // R2: first output octet after fifth accepted octet
        chk(first_out_sent == DEPTH + 1, "R2 latency", first_out_sent, DEPTH + 1);
        // R12: cell with input gaps keeps order
        send_cell(8'h00, 8'h00, 8'h01, 8'h01, 40, 1'b1, 1'b0, 0, 0);
        flush_and_compare("R2 R12 passthrough");
        chk(nferr == 0, "R12 no framing error", nferr, 0);
    endtask

    task automatic t_idle();
        do_reset(8'h01, 8'h00);
        send_cell(8'h00, 8'h00, 8'h00, 8'h01, 10, 1'b0, 1'b0, 0, 0);
        send_cell(8'h00, 8'h00, 8'h00, 8'h09, 20, 1'b0, 1'b0, 0, 0);
        send_cell(8'h10, 8'h00, 8'h00, 8'h01, 30, 1'b0, 1'b0, 0, 0);
        // R5 R8: idle removed in full, OAM-style 09 kept
        flush_and_compare("R5 R8 idle only");
        chk(exp_drops == 1 && drop_count == 1, "R5 count", int'(drop_count), 1);
    endtask

    task automatic t_phys();
        do_reset(8'h01, 8'hFE);
        send_cell(8'hA0, 8'h00, 8'h00, 8'h0B, 1, 1'b0, 1'b0, 0, 0);
        send_cell(8'h00, 8'h00, 8'h00, 8'h01, 2, 1'b0, 1'b0, 0, 0);
        send_cell(8'h00, 8'h00, 8'h00, 8'h09, 3, 1'b0, 1'b0, 0, 0);
        send_cell(8'h00, 8'h00, 8'h00, 8'h02, 4, 1'b0, 1'b0, 0, 0);
        send_cell(8'hA0, 8'h00, 8'h00, 8'h1B, 5, 1'b0, 1'b0, 0, 0);
        // R6: three physical-layer cells removed; LSB 0 and R4 nonzero octet-4 high kept
        flush_and_compare("R6 R3 physical layer");
        chk(drop_count == 3, "R6 count", int'(drop_count), 3);
    endtask

    task automatic t_unassigned();
        do_reset(8'h00, 8'h0E);
        send_cell(8'h00, 8'h00, 8'h00, 8'h06, 7, 1'b0, 1'b0, 0, 0);
        send_cell(8'h00, 8'h00, 8'h00, 8'h00, 8, 1'b0, 1'b0, 0, 0);
        send_cell(8'h00, 8'h00, 8'h00, 8'h01, 9, 1'b0, 1'b0, 0, 0);
        // R7
        flush_and_compare("R7 unassigned");
        chk(drop_count == 2, "R7 count", int'(drop_count), 2);
    endtask

    task automatic t_zero_bits();
        do_reset(8'h01, 8'hFF);
        send_cell(8'h05, 8'h00, 8'h00, 8'h01, 11, 1'b0, 1'b0, 0, 0);
        send_cell(8'h00, 8'h80, 8'h00, 8'h01, 12, 1'b0, 1'b0, 0, 0);
        send_cell(8'h00, 8'h00, 8'h01, 8'h01, 13, 1'b0, 1'b0, 0, 0);
        send_cell(8'hF0, 8'h00, 8'h00, 8'h0E, 14, 1'b0, 1'b0, 0, 0);
        // R4: only the last cell has zeros outside the compared nibbles
        flush_and_compare("R4 fixed zero bits");
        chk(drop_count == 1, "R4 count", int'(drop_count), 1);
    endtask

    task automatic t_cfg_mid();
        do_reset(8'h01, 8'h00);
        send_cell(8'h00, 8'h00, 8'h00, 8'h01, 15, 1'b0, 1'b1, 8'h55, 8'h00);
        send_cell(8'h00, 8'h00, 8'h00, 8'h01, 16, 1'b0, 1'b1, 8'h01, 8'h00);
        // R9: first dropped despite change, second kept (0x55 sampled)
        flush_and_compare("R9 config sampling");
        chk(drop_count == 1, "R9 count", int'(drop_count), 1);
    endtask

    task automatic t_early_soc();
        do_reset(8'h01, 8'h00);
        send_partial(2);
        send_cell(8'h00, 8'h00, 8'h00, 8'h01, 17, 1'b0, 1'b0, 0, 0);
        // R11
        flush_and_compare("R11 early start");
        chk(nferr == 1, "R11 frame_err pulses", nferr, 1);
        chk(drop_count == 1, "R11 resync count", int'(drop_count), 1);
    endtask

    task automatic t_saturate();
        do_reset(8'h01, 8'h00);
        for (int c = 0; c < 7; c++) send_cell(8'h00, 8'h00, 8'h00, 8'h01, c, 1'b0, 1'b0, 0, 0);
        gap(2);
        // R10
        chk(drop_count == 7, "R10 count at max", int'(drop_count), 7);
        for (int c = 0; c < 2; c++) send_cell(8'h00, 8'h00, 8'h00, 8'h01, c, 1'b0, 1'b0, 0, 0);
        flush_and_compare("R10 saturation");
        chk(drop_count == 7, "R10 count saturated", int'(drop_count), 7);
    endtask

    initial begin
        t_reset();
        t_pass();
        t_idle();
        t_phys();
        t_unassigned();
        t_zero_bits();
        t_cfg_mid();
        t_early_soc();
        t_saturate();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule